// File: doc/BRIEF.md
# Register Context Save/Restore Sequencer

This block moves the complete state of a wide register file to and from memory, one 64-bit word at a time. Each register entry is 66 bits: a 64-bit value, a carry bit at position 64 and an overflow bit at position 65. The memory side is 64 bits wide, so the two extra bits of every register cannot travel with the value. Instead the sequencer works in groups of 32 registers. It gathers the 64 status bits of a group into a single flag word, and stores that word in front of the group's register values.

A save is started with a base address. The sequencer streams each group's register values to memory in ascending address order. It then writes the group's flag word back into the slot it skipped at the head of the group. A restore reads memory strictly in ascending address order. Each flag word therefore arrives first and is held in a latch. The following 32 values are then written into the register file with their status bits taken from that latch. When integrity mode is requested, a CRC-32 of the saved stream is appended after the last group on save. On restore that word is checked, and a mismatch is flagged together with completion.

The controller states are: `ST_IDLE` (waiting for a command), `ST_SV_REG` (writing one register value), `ST_SV_FLAG` (writing the group flag word), `ST_SV_CRC` (writing the checksum), `ST_RS_FLAG_REQ`/`ST_RS_FLAG_WAIT` (reading a flag word), `ST_RS_REG_REQ`/`ST_RS_REG_WAIT` (reading one register value and writing it into the file), `ST_RS_CRC_REQ`/`ST_RS_CRC_WAIT` (reading and comparing the checksum) and `ST_FINISH` (the one-cycle completion). The transitions are as follows:
- IDLE goes to SV_REG or RS_FLAG_REQ on an accepted start.
- SV_REG goes to SV_FLAG after the 32nd value of a group.
- SV_FLAG goes back to SV_REG for the next group. After the last group it goes to SV_CRC or FINISH.
- RS_FLAG_WAIT goes to RS_REG_REQ.
- RS_REG_WAIT goes back to RS_REG_REQ within a group, and to RS_FLAG_REQ at a group boundary. After the last group it goes to RS_CRC_REQ or FINISH.
- RS_CRC_WAIT goes to FINISH.
- FINISH goes to IDLE.

Top module: `ctx_seq`

## Requirements
- R1: After reset, busy, done, crc_err, mem_req_valid and rf_we are all 0.
- R2: Group g (0..7) occupies the 33 words starting at base + 33*g. Its flag word is at offset 0 and register 32*g+i is at offset 1+i. The checksum slot is base + 264.
- R3: In a flag word, bit 2*i holds bit 64 (carry) of the group's register i and bit 2*i+1 holds bit 65 (overflow).
- R4: A save issues only writes. For each group, in ascending group order, it writes the 32 register values at ascending addresses and then the group's flag word at offset 0.
- R5: A restore issues only reads, at strictly ascending addresses starting at base. A group's flag word is therefore read before any register of that group is written.
- R6: A restore writes register 32*g+i exactly once, on the cycle its read data returns. The written entry has bits 63:0 equal to the returned word, bit 64 equal to flag bit 2*i and bit 65 equal to flag bit 2*i+1.
- R7: With integrity mode on, a save ends with one extra write to the checksum slot. That word holds zero in bits 63:32 and a CRC-32 in bits 31:0. The CRC is computed over, for each group in turn, the 32 register values and then the flag word, each word taken LSB first. It uses polynomial 0xEDB88320 (reflected), an initial value of all ones and an inverted result. With integrity mode off, no such write occurs.
- R8: With integrity mode on, a restore also reads the checksum slot. crc_err is 1 during the done cycle exactly when the stored word differs from the CRC of the data returned. crc_err is 0 at all other times.
- R9: At most one read is outstanding. No request is issued between a read handshake and its response, and a request held without ready keeps its address, direction and data.
- R10: busy is 1 from the cycle after an accepted start through the done cycle. done is high for exactly one cycle per operation.
- R11: A start while busy is ignored. The running operation's memory traffic is unchanged and only one done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| start_restore | input | 1 | 1 = restore, 0 = save |
| start_crc | input | 1 | Enable checksum word |
| start_base | input | 32 | Base word address of the context image |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Checksum mismatch, valid with done |
| rf_raddr | output | 8 | Register file read index |
| rf_rdata | input | 66 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 8 | Register file write index |
| rf_wdata | output | 66 | Register file write data {ovf, carry, value} |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |

## Verification
The bench targets the out-of-order flag write on save. A design that wrote the flag word before its group, or at the wrong slot, would show a misplaced address in the compared request stream. Restore runs with random-looking response latency and stalled ready. A sequencer that wrote registers before the flag latch was loaded, or that swapped carry and overflow, would leave wrong bits 64/65 in the file. A checksum fed in a different word order would set crc_err on a clean image, and one that ignored data would miss a single flipped bit in memory. A second start fired mid-run would, if honoured, show up as extra or redirected traffic and a second done.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SV_REG,
        ST_SV_FLAG,
        ST_SV_CRC,
        ST_RS_FLAG_REQ,
        ST_RS_FLAG_WAIT,
        ST_RS_REG_REQ,
        ST_RS_REG_WAIT,
        ST_RS_CRC_REQ,
        ST_RS_CRC_WAIT,
        ST_FINISH
    } ctx_state_e;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

endpackage

// File: rtl/ctx_crc_step.sv
module ctx_crc_step
    import ctx_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc_out
);

    // Bit-serial reflected CRC, unrolled over one word, LSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < WORD_W; b++) begin
            fb = c[0] ^ word[b];
            c  = c >> 1;
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/ctx_cursor.sv
module ctx_cursor #(
    parameter int ADDR_W     = 32,
    parameter int GROUP_REGS = 32,
    parameter int NUM_GROUPS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [ADDR_W-1:0]             base,
    input  logic                          step_idx,
    input  logic                          step_grp,
    output logic [$clog2(GROUP_REGS)-1:0] idx,
    output logic [$clog2(NUM_GROUPS)-1:0] grp,
    output logic [ADDR_W-1:0]             gbase,
    output logic                          idx_last,
    output logic                          grp_last
);

    localparam int IDX_W  = $clog2(GROUP_REGS);
    localparam int GRP_W  = $clog2(NUM_GROUPS);
    localparam int STRIDE = GROUP_REGS + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            grp   <= '0;
            gbase <= '0;
        end else if (load) begin
            idx   <= '0;
            grp   <= '0;
            gbase <= base;
        end else if (step_grp) begin
            idx   <= '0;
            grp   <= grp + GRP_W'(1);
            gbase <= gbase + ADDR_W'(STRIDE);
        end else if (step_idx) begin
            idx   <= idx_last ? '0 : idx + IDX_W'(1);
        end
    end

    assign idx_last = (idx == IDX_W'(GROUP_REGS - 1));
    assign grp_last = (grp == GRP_W'(NUM_GROUPS - 1));

endmodule

// File: rtl/ctx_flag_latch.sv
module ctx_flag_latch #(
    parameter int WORD_W = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            load,
    input  logic [WORD_W-1:0]               load_word,
    input  logic                            set,
    input  logic [$clog2(WORD_W/2)-1:0]     set_idx,
    input  logic                            set_c,
    input  logic                            set_o,
    input  logic [$clog2(WORD_W/2)-1:0]     sel_idx,
    output logic [WORD_W-1:0]               word,
    output logic                            sel_c,
    output logic                            sel_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= load_word;
        end else if (set) begin
            word[{set_idx, 1'b0}] <= set_c;
            word[{set_idx, 1'b1}] <= set_o;
        end else if (clear) begin
            word <= '0;
        end
    end

    assign sel_c = word[{sel_idx, 1'b0}];
    assign sel_o = word[{sel_idx, 1'b1}];

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int NUM_REGS = 256,
    parameter int WORD_W   = 64,
    parameter int ADDR_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          start_restore,
    input  logic                          start_crc,
    input  logic [ADDR_W-1:0]             start_base,
    output logic                          busy,
    output logic                          done,
    output logic                          crc_err,
    output logic [$clog2(NUM_REGS)-1:0]   rf_raddr,
    input  logic [WORD_W+1:0]             rf_rdata,
    output logic                          rf_we,
    output logic [$clog2(NUM_REGS)-1:0]   rf_waddr,
    output logic [WORD_W+1:0]             rf_wdata,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic                          mem_req_write,
    output logic [ADDR_W-1:0]             mem_req_addr,
    output logic [WORD_W-1:0]             mem_req_wdata,
    input  logic                          mem_rsp_valid,
    input  logic [WORD_W-1:0]             mem_rsp_rdata
);

    localparam int GROUP_REGS = WORD_W / 2;
    localparam int NUM_GROUPS = NUM_REGS / GROUP_REGS;
    localparam int IDX_W      = $clog2(GROUP_REGS);
    localparam int GRP_W      = $clog2(NUM_GROUPS);
    localparam int RIDX_W     = $clog2(NUM_REGS);
    localparam int PAD_W      = WORD_W - CRC_W;

    ctx_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx;
    logic [GRP_W-1:0]  grp;
    logic [ADDR_W-1:0] gbase;
    logic              idx_last, grp_last;

    logic [WORD_W-1:0] flag_word;
    logic              sel_c, sel_o;

    logic [CRC_W-1:0]  crc_q, crc_a, crc_b;
    logic [WORD_W-1:0] crc_feed;
    logic [WORD_W-1:0] crc_word;
    logic              crc_en_q;
    logic              err_q;

    logic start_ok, hs, rsp;
    logic cur_step_idx, cur_step_grp;
    logic fl_clear, fl_load, fl_set;

    assign start_ok = start && (state_q == ST_IDLE);
    assign hs       = mem_req_valid && mem_req_ready;
    assign rsp      = mem_rsp_valid;
    assign crc_word = {{PAD_W{1'b0}}, ~crc_q};

    ctx_cursor #(
        .ADDR_W     (ADDR_W),
        .GROUP_REGS (GROUP_REGS),
        .NUM_GROUPS (NUM_GROUPS)
    ) cursor_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .base     (start_base),
        .step_idx (cur_step_idx),
        .step_grp (cur_step_grp),
        .idx      (idx),
        .grp      (grp),
        .gbase    (gbase),
        .idx_last (idx_last),
        .grp_last (grp_last)
    );

    ctx_flag_latch #(
        .WORD_W (WORD_W)
    ) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fl_clear),
        .load      (fl_load),
        .load_word (mem_rsp_rdata),
        .set       (fl_set),
        .set_idx   (idx),
        .set_c     (rf_rdata[WORD_W]),
        .set_o     (rf_rdata[WORD_W+1]),
        .sel_idx   (idx),
        .word      (flag_word),
        .sel_c     (sel_c),
        .sel_o     (sel_o)
    );

    ctx_crc_step #(.WORD_W(WORD_W)) crc_data_i (
        .crc_in  (crc_q),
        .word    (crc_feed),
        .crc_out (crc_a)
    );

    ctx_crc_step #(.WORD_W(WORD_W)) crc_flag_i (
        .crc_in  (crc_a),
        .word    (flag_word),
        .crc_out (crc_b)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = start_restore ? ST_RS_FLAG_REQ : ST_SV_REG;
                end
            end
            ST_SV_REG: begin
                if (hs && idx_last) begin
                    state_d = ST_SV_FLAG;
                end
            end
            ST_SV_FLAG: begin
                if (hs) begin
                    if (!grp_last) begin
                        state_d = ST_SV_REG;
                    end else begin
                        state_d = crc_en_q ? ST_SV_CRC : ST_FINISH;
                    end
                end
            end
            ST_SV_CRC: begin
                if (hs) begin
                    state_d = ST_FINISH;
                end
            end
            ST_RS_FLAG_REQ: begin
                if (hs) begin
                    state_d = ST_RS_FLAG_WAIT;
                end
            end
            ST_RS_FLAG_WAIT: begin
                if (rsp) begin
                    state_d = ST_RS_REG_REQ;
                end
            end
            ST_RS_REG_REQ: begin
                if (hs) begin
                    state_d = ST_RS_REG_WAIT;
                end
            end
            ST_RS_REG_WAIT: begin
                if (rsp) begin
                    if (!idx_last) begin
                        state_d = ST_RS_REG_REQ;
                    end else if (!grp_last) begin
                        state_d = ST_RS_FLAG_REQ;
                    end else begin
                        state_d = crc_en_q ? ST_RS_CRC_REQ : ST_FINISH;
                    end
                end
            end
            ST_RS_CRC_REQ: begin
                if (hs) begin
                    state_d = ST_RS_CRC_WAIT;
                end
            end
            ST_RS_CRC_WAIT: begin
                if (rsp) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_FINISH);
        crc_err       = (state_q == ST_FINISH) && err_q;
        rf_raddr      = RIDX_W'({grp, idx});
        rf_waddr      = RIDX_W'({grp, idx});
        rf_wdata      = {sel_o, sel_c, mem_rsp_rdata};
        rf_we         = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = gbase;
        mem_req_wdata = '0;
        crc_feed      = mem_rsp_rdata;
        cur_step_idx  = 1'b0;
        cur_step_grp  = 1'b0;
        fl_clear      = start_ok;
        fl_load       = 1'b0;
        fl_set        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SV_REG: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = gbase + ADDR_W'(idx) + ADDR_W'(1);
                mem_req_wdata = rf_rdata[WORD_W-1:0];
                crc_feed      = rf_rdata[WORD_W-1:0];
                cur_step_idx  = hs;
                fl_set        = hs;
            end
            ST_SV_FLAG: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = flag_word;
                crc_feed      = flag_word;
                cur_step_grp  = hs;
                fl_clear      = hs;
            end
            ST_SV_CRC: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = crc_word;
            end
            ST_RS_FLAG_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_RS_FLAG_WAIT: begin
                fl_load = rsp;
            end
            ST_RS_REG_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = gbase + ADDR_W'(idx) + ADDR_W'(1);
            end
            ST_RS_REG_WAIT: begin
                rf_we        = rsp;
                cur_step_idx = rsp && !idx_last;
                cur_step_grp = rsp && idx_last;
            end
            ST_RS_CRC_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_RS_CRC_WAIT: begin
            end
            ST_FINISH: begin
            end
            default: begin
            end
        endcase
    end

    // Checksum accumulator, integrity mode and error latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q    <= CRC_INIT;
            crc_en_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (start_ok) begin
            crc_q    <= CRC_INIT;
            crc_en_q <= start_crc;
            err_q    <= 1'b0;
        end else begin
            if (hs && (state_q == ST_SV_REG || state_q == ST_SV_FLAG)) begin
                crc_q <= crc_a;
            end
            if (rsp && state_q == ST_RS_REG_WAIT) begin
                crc_q <= idx_last ? crc_b : crc_a;
            end
            if (rsp && state_q == ST_RS_CRC_WAIT) begin
                err_q <= (mem_rsp_rdata != crc_word);
            end
        end
    end

endmodule

// File: rtl/ctx_seq_chk.sv
module ctx_seq_chk #(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              crc_err,
    input logic              rf_we,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [WORD_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid
);

    logic rd_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            rd_pend <= 1'b1;
        end else if (mem_rsp_valid) begin
            rd_pend <= 1'b0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                                   // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !rf_we));                            // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)));        // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !mem_req_valid);                                      // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> done);                                                // R8
    AST_RF_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_rsp_valid && rd_pend && !mem_req_valid));          // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);                               // R11

endmodule

bind ctx_seq ctx_seq_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .crc_err       (crc_err),
    .rf_we         (rf_we),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/ctx_seq_tb_top.sv
`timescale 1ns/1ps
module ctx_seq_tb_top;

    localparam int NR = 256;
    localparam int MAXQ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_restore = 1'b0;
    logic        start_crc = 1'b0;
    logic [31:0] start_base = '0;
    logic        busy, done, crc_err;
    logic [7:0]  rf_raddr, rf_waddr;
    logic [65:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    ctx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_restore(start_restore),
        .start_crc(start_crc), .start_base(start_base), .busy(busy), .done(done),
        .crc_err(crc_err), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Behavioural model state
    logic [65:0] rf_m   [NR];      // written by stimulus only
    logic [65:0] rf_got [NR];      // written by monitor only
    logic [63:0] mem    [1024];    // written by monitor only
    logic        ew [MAXQ];
    logic [31:0] ea [MAXQ];
    logic [63:0] ed [MAXQ];
    logic [7:0]  xa [MAXQ];
    logic [65:0] xd [MAXQ];
    int en = 0, ep = 0, xn = 0, xp = 0;
    int chk_a = 0, fail_a = 0, chk_m = 0, fail_m = 0, fail_w = 0;
    int done_cnt = 0, rd_issued = 0, rd_served = 0, wait_cnt = 0, cyc = 0;
    logic [31:0] rd_addr = '0;
    logic        done_prev = 1'b0;
    logic        corrupt = 1'b0;
    logic [31:0] corrupt_addr = '0;

    assign rf_rdata = rf_m[rf_raddr];

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [63:0] w);
        logic [31:0] r = c;
        for (int j = 0; j < 64; j++) begin
            logic b = r[0] ^ w[j];
            r = r >> 1;
            if (b) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [63:0] served(input logic [31:0] a);
        return mem[a[9:0]] ^ ((corrupt && a == corrupt_addr) ? 64'h1 : 64'h0);
    endfunction

    // Monitor: compares every handshake and register write against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && mem_req_ready) begin
                chk_m++;
                if (ep >= en) begin
                    fail_m++;
                    $display("FAIL R4/R5 unexpected request w=%0b addr=%0h expected none", mem_req_write, mem_req_addr);
                end else if (mem_req_write !== ew[ep] || mem_req_addr !== ea[ep] ||
                             (ew[ep] && mem_req_wdata !== ed[ep])) begin
                    fail_m++;
                    $display("FAIL R2/R3/R4/R5/R7 req w=%0b addr=%0h data=%0h expected w=%0b addr=%0h data=%0h",
                             mem_req_write, mem_req_addr, mem_req_wdata, ew[ep], ea[ep], ed[ep]);
                end
                ep++;
                if (mem_req_write) mem[mem_req_addr[9:0]] = mem_req_wdata;
                else begin
                    rd_addr = mem_req_addr;
                    rd_issued++;
                end
            end
            if (rf_we) begin
                chk_m++;
                if (xp >= xn) begin
                    fail_m++;
                    $display("FAIL R6 unexpected rf write idx=%0d expected none", rf_waddr);
                end else if (rf_waddr !== xa[xp] || rf_wdata !== xd[xp]) begin
                    fail_m++;
                    $display("FAIL R6 rf write idx=%0d data=%0h expected idx=%0d data=%0h",
                             rf_waddr, rf_wdata, xa[xp], xd[xp]);
                end
                xp++;
                rf_got[rf_waddr] = rf_wdata;
            end
            if (done) begin
                done_cnt++;
                if (done_prev) begin
                    chk_m++; fail_m++;
                    $display("FAIL R10 done high two cycles actual=1 expected=0");
                end
            end
            done_prev = done;
        end
    end

    // Memory responder: stalls ready, returns reads after 1..3 cycles
    always @(posedge clk) begin
        #1;
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rd_issued != rd_served) begin
            if (wait_cnt >= (rd_served % 3)) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = served(rd_addr);
                rd_served++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
        mem_req_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
    end

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        chk_a++;
        if (act !== exp) begin
            fail_a++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_rf(input logic [63:0] seed, input bit all_flags);
        for (int k = 0; k < NR; k++) begin
            logic [63:0] v = (64'(k) * 64'h9E3779B97F4A7C15) ^ seed;
            logic [1:0]  f = all_flags ? 2'b11 : 2'((k * 3 + seed[3:0]) % 4);
            rf_m[k] = {f, v};
        end
    endtask

    // Runs one command; builds the expected stream first
    task automatic run_op(input bit restore, input logic [31:0] base, input bit crc,
                          input bit poke, input bit exp_err, input string tag);
        logic [31:0] c = 32'hFFFFFFFF;
        int d0 = done_cnt;
        bit seen = 0;
        for (int g = 0; g < 8; g++) begin
            logic [31:0] gb = base + 32'(33 * g);
            logic [63:0] fw = '0;
            if (restore) begin
                fw = served(gb);
                ew[en] = 0; ea[en] = gb; ed[en] = '0; en++;
            end
            for (int i = 0; i < 32; i++) begin
                if (restore) begin
                    logic [63:0] d = served(gb + 32'(1 + i));
                    ew[en] = 0; ea[en] = gb + 32'(1 + i); ed[en] = '0; en++;
                    xa[xn] = 8'(32 * g + i); xd[xn] = {fw[2*i+1], fw[2*i], d}; xn++;
                    c = crc_upd(c, d);
                end else begin
                    logic [65:0] r = rf_m[32 * g + i];
                    ew[en] = 1; ea[en] = gb + 32'(1 + i); ed[en] = r[63:0]; en++;
                    fw[2*i] = r[64]; fw[2*i+1] = r[65];
                    c = crc_upd(c, r[63:0]);
                end
            end
            if (!restore) begin
                ew[en] = 1; ea[en] = gb; ed[en] = fw; en++;
            end
            c = crc_upd(c, fw);
        end
        if (crc) begin
            ew[en] = !restore; ea[en] = base + 32'd264; ed[en] = {32'h0, ~c}; en++;
        end
        @(negedge clk);
        start = 1; start_restore = restore; start_crc = crc; start_base = base;
        @(negedge clk);
        start = 0;
        check({tag, " R10 busy after start"}, 66'(busy), 66'd1);
        for (int n = 0; n < 5000 && !seen; n++) begin
            @(negedge clk);
            if (poke && n == 40) begin
                start = 1; start_restore = !restore; start_base = base + 32'd7;
            end else begin
                start = 0;
            end
            if (done) begin
                seen = 1;
                check({tag, " R8 crc_err with done"}, 66'(crc_err), 66'(exp_err));
                check({tag, " R10 busy in done cycle"}, 66'(busy), 66'd1);
            end else if (crc_err) begin
                check({tag, " R8 crc_err outside done"}, 66'(crc_err), 66'd0);
            end
        end
        if (!seen) check({tag, " R10 done never seen"}, 66'd0, 66'd1);
        @(negedge clk);
        check({tag, " R10 idle after done"}, 66'({busy, done}), 66'd0);
        check({tag, " R11 one done per command"}, 66'(done_cnt - d0), 66'd1);
        check({tag, " R4/R5 all requests issued"}, 66'(ep), 66'(en));
        check({tag, " R6 all rf writes issued"}, 66'(xp), 66'(xn));
    endtask

    task automatic check_rf(input string tag);
        int bad = 0;
        for (int k = 0; k < NR; k++) begin
            chk_a++;
            if (rf_got[k] !== rf_m[k]) begin
                fail_a++; bad++;
                if (bad < 4) $display("FAIL %s R6 reg %0d actual=%0h expected=%0h", tag, k, rf_got[k], rf_m[k]);
            end
        end
    endtask

    initial begin
        #(150000 * 5);
        fail_w = 1;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", chk_a + chk_m + 1, fail_a + fail_m + fail_w);
        $finish;
    end

    initial begin
        for (int k = 0; k < NR; k++) rf_got[k] = '0;
        fill_rf(64'h0123_4567_89AB_CDEF, 0);
        repeat (4) @(negedge clk);
        check("R1 busy reset", 66'(busy), 66'd0);
        check("R1 done reset", 66'(done), 66'd0);
        check("R1 req reset", 66'(mem_req_valid), 66'd0);
        check("R1 rf_we reset", 66'(rf_we), 66'd0);
        check("R1 crc_err reset", 66'(crc_err), 66'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: plain save, then plain restore into cleared copy (R5 R6)
        run_op(0, 32'd16, 0, 0, 0, "save-plain");
        run_op(1, 32'd16, 0, 0, 0, "restore-plain");
        check_rf("restore-plain");

        // R7 with all flags set, R8 clean restore
        fill_rf(64'hFEDC_BA98_7654_3210, 1);
        run_op(0, 32'd300, 1, 0, 0, "save-crc");
        run_op(1, 32'd300, 1, 0, 0, "restore-crc");
        check_rf("restore-crc");

        // R8: one flipped bit in a register word is detected
        corrupt = 1; corrupt_addr = 32'd300 + 32'd5;
        run_op(1, 32'd300, 1, 0, 1, "restore-corrupt");
        corrupt = 0;

        // R11: start pulse in the middle of a run is ignored
        fill_rf(64'h5A5A_0F0F_C3C3_9696, 0);
        run_op(0, 32'd600, 1, 1, 0, "save-poke");
        run_op(1, 32'd600, 1, 1, 0, "restore-poke");
        check_rf("restore-poke");

        $display("== %0d vectors applied, %0d miscompares ==", chk_a + chk_m, fail_a + fail_m + fail_w);
        $finish;
    end

endmodule